// File: doc/BRIEF.md
# Quadrature Edge-Pulse Velocity Estimator

This block turns a pair of quadrature position-sensor phases into a signed digital velocity word. Both phases are resynchronised to the system clock and combined by an exclusive-OR. The combined signal toggles on every edge of either phase, so it changes state twice as often as either phase alone. A clocked delay line fires a pulse of fixed length after each change of that signal. The share of clock cycles in which the pulse is high grows linearly with carriage speed.

A window counter sums the pulse-high cycles over a fixed span of `WINDOW` clocks. At the end of each span it latches the total as a signed word and raises a one-cycle strobe. The stored magnitude is negated when the direction input says reverse. A mode enable gates the output to zero without disturbing the stored value. The word is meant to be fed to a servo summing stage, which reads it on each strobe.

Top module: `quad_vel_est`

## Requirements
- R1: Every change of the exclusive-OR of the two synchronised phases yields a pulse that is high for exactly `DELAY_TAPS` clock cycles, provided transitions are spaced at least `DELAY_TAPS` cycles apart.
- R2: With transitions of the combined signal every P cycles (P >= `DELAY_TAPS`, `WINDOW` a multiple of P), the latched magnitude in steady state is `WINDOW*DELAY_TAPS/P` (64, 32, 16, 8, 4 for P = 4, 8, 16, 32, 64 at defaults 4 and 64).
- R3: When transitions come closer together than the pulse width, the pulse stays high and the magnitude saturates at `WINDOW`; the output never exceeds `WINDOW` in magnitude and never wraps.
- R4: `vel_o` is two's complement; the magnitude is stored positive when `fwd_i` is 1 and negated when `fwd_i` is 0, with `fwd_i` sampled on the clock edge that ends the window.
- R5: While `vel_en_i` is 0, `vel_o` reads 0. The stored value is kept, and it reappears as soon as `vel_en_i` returns to 1.
- R6: `vel_valid_o` is a one-cycle strobe, raised once every `WINDOW` clocks. The first strobe comes on the `WINDOW`-th rising edge after reset is released.
- R7: While `rst_ni` is low, `vel_o` and `vel_valid_o` are 0. Reset also clears the delay line and both counters.
- R8: With both phases held still, the latched magnitude is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_a_i | input | 1 | Quadrature phase A, asynchronous |
| phase_b_i | input | 1 | Quadrature phase B, asynchronous |
| fwd_i | input | 1 | Direction: 1 forward, 0 reverse (synchronous) |
| vel_en_i | input | 1 | Velocity-mode enable; output forced to 0 when low |
| vel_o | output | OUT_W | Signed velocity estimate |
| vel_valid_o | output | 1 | One-cycle strobe marking a new estimate |

## Verification
The assertions check four things on every cycle: that the strobe never lasts two cycles, that the output magnitude stays within `WINDOW`, that the output holds between strobes while enabled, and that the sign of every new nonzero estimate follows the sampled direction. The linear relation between edge rate and count, the saturation under dense edges, the zero result at standstill and the exact timing of the first strobe depend on whole windows of stimulus. Only the bench's pattern runs and directed reset cases can show them.

// File: rtl/qve_pkg.sv
package qve_pkg;
  // Bits needed to hold values 0..n inclusive.
  function automatic int unsigned cnt_width(int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/qve_sync.sv
module qve_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        stab_q <= meta_q;
      end
    end
    assign sync_o[g] = stab_q;
  end
endmodule

// File: rtl/qve_edge_pulse.sv
module qve_edge_pulse #(
  parameter int unsigned DELAY_TAPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ph_a_i,
  input  logic ph_b_i,
  output logic pulse_o
);
  logic                  comb_w;
  logic [DELAY_TAPS-1:0] dl_q;
  logic [DELAY_TAPS:0]   taps_w;

  assign comb_w = ph_a_i ^ ph_b_i;

  if (DELAY_TAPS == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dl_q <= '0;
      else         dl_q <= comb_w;
    end
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) dl_q <= '0;
      else         dl_q <= {dl_q[DELAY_TAPS-2:0], comb_w};
    end
  end

  // High while any tap disagrees: equals end-tap XOR for sparse edges,
  // stays high (no cancellation) for dense edges.
  assign taps_w  = {dl_q, comb_w};
  assign pulse_o = (|taps_w) & ~(&taps_w);
endmodule

// File: rtl/qve_duty_window.sv
module qve_duty_window #(
  parameter int unsigned WINDOW = 64,
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned OUT_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pulse_i,
  input  logic                    fwd_i,
  output logic signed [OUT_W-1:0] vel_o,
  output logic                    valid_o
);
  localparam int unsigned WCNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

  logic [WCNT_W-1:0] win_q;
  logic [CNT_W-1:0]  acc_q, acc_next;
  logic              last_w;
  logic signed [OUT_W-1:0] mag_w;

  assign last_w   = (win_q == WCNT_W'(WINDOW - 1));
  assign acc_next = acc_q + CNT_W'(pulse_i);
  assign mag_w    = $signed(OUT_W'(acc_next));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      acc_q   <= '0;
      vel_o   <= '0;
      valid_o <= 1'b0;
    end else if (last_w) begin
      win_q   <= '0;
      acc_q   <= '0;
      vel_o   <= fwd_i ? mag_w : -mag_w;
      valid_o <= 1'b1;
    end else begin
      win_q   <= win_q + 1'b1;
      acc_q   <= acc_next;
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_vel_est.sv
module quad_vel_est #(
  parameter int unsigned DELAY_TAPS = 4,
  parameter int unsigned WINDOW     = 64,
  localparam int unsigned CNT_W     = qve_pkg::cnt_width(WINDOW),
  localparam int unsigned OUT_W     = CNT_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    phase_a_i,
  input  logic                    phase_b_i,
  input  logic                    fwd_i,
  input  logic                    vel_en_i,
  output logic signed [OUT_W-1:0] vel_o,
  output logic                    vel_valid_o
);
  logic [1:0]              ph_sync_w;
  logic                    pulse_w;
  logic signed [OUT_W-1:0] vel_q_w;

  qve_sync #(.WIDTH(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({phase_b_i, phase_a_i}),
    .sync_o (ph_sync_w)
  );

  qve_edge_pulse #(.DELAY_TAPS(DELAY_TAPS)) u_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ph_a_i (ph_sync_w[0]),
    .ph_b_i (ph_sync_w[1]),
    .pulse_o(pulse_w)
  );

  qve_duty_window #(.WINDOW(WINDOW), .CNT_W(CNT_W), .OUT_W(OUT_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(pulse_w),
    .fwd_i  (fwd_i),
    .vel_o  (vel_q_w),
    .valid_o(vel_valid_o)
  );

  assign vel_o = vel_en_i ? vel_q_w : '0;
endmodule

// File: rtl/quad_vel_est_chk.sv
module quad_vel_est_chk #(
  parameter int unsigned WINDOW = 64,
  parameter int unsigned OUT_W  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    fwd_i,
  input logic                    vel_en_i,
  input logic signed [OUT_W-1:0] vel_o,
  input logic                    vel_valid_o
);
  // R6
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vel_valid_o |=> !vel_valid_o);

  // R3
  mag_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(vel_o) <= int'(WINDOW)) && (int'(vel_o) >= -int'(WINDOW)));

  // R5
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vel_en_i && $past(vel_en_i) && !vel_valid_o) |-> $stable(vel_o));

  // R4
  sign_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vel_valid_o && vel_en_i && (vel_o != '0)) |-> ((vel_o < 0) == !$past(fwd_i)));
endmodule

bind quad_vel_est quad_vel_est_chk #(.WINDOW(WINDOW), .OUT_W(OUT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fwd_i      (fwd_i),
  .vel_en_i   (vel_en_i),
  .vel_o      (vel_o),
  .vel_valid_o(vel_valid_o)
);

// File: tb/quad_vel_est_tb.sv
module quad_vel_est_tb_top;
  localparam int NV = 12;
  // period (0 = still), fwd, en, expected
  localparam int PER_T[NV] = '{0, 64, 32, 16,  8,   8,  4,  2,   1,  16, 16,  8};
  localparam bit FWD_T[NV] = '{1,  1,  1,  1,  1,   0,  1,  1,   0,   0,  1,  0};
  localparam bit EN_T [NV] = '{1,  1,  1,  1,  1,   1,  1,  1,   1,   1,  0,  0};
  localparam int EXP_T[NV] = '{0,  4,  8, 16, 32, -32, 64, 64, -64, -16,  0,  0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_r = 1'b0, b_r = 1'b0, fwd_r = 1'b1, en_r = 1'b1;
  logic signed [7:0] vel_o;
  logic vel_valid_o;
  int checks = 0, errors = 0;
  bit sel = 1'b0;

  always #10 clk = ~clk;

  quad_vel_est dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_a_i(a_r), .phase_b_i(b_r),
    .fwd_i(fwd_r), .vel_en_i(en_r), .vel_o(vel_o), .vel_valid_o(vel_valid_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Toggle A and B alternately every per cycles; return value at third strobe.
  task automatic run_pattern(int per, bit fwd, bit en, output int got);
    int seen = 0;
    int ctr = 0;
    fwd_r = fwd;
    en_r = en;
    got = 9999;
    while (seen < 3) begin
      @(negedge clk);
      if (vel_valid_o) begin
        seen++;
        if (seen == 3) got = int'(vel_o);
      end
      if (per > 0) begin
        ctr++;
        if (ctr >= per) begin
          ctr = 0;
          if (sel) b_r = ~b_r; else a_r = ~a_r;
          sel = ~sel;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got;
    int first;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 vel_o in reset", int'(vel_o), 0);
    chk("R7 valid in reset", int'(vel_valid_o), 0);
    rst_n = 1'b1;
    // R6: first strobe on the WINDOW-th edge
    first = 0;
    for (int k = 1; k <= 80 && first == 0; k++) begin
      @(negedge clk);
      if (vel_valid_o) first = k;
    end
    chk("R6 first strobe cycle", first, 64);
    @(negedge clk);
    chk("R6 strobe one cycle", int'(vel_valid_o), 0);
    first = 0;
    for (int k = 2; k <= 80 && first == 0; k++) begin
      @(negedge clk);
      if (vel_valid_o) first = k;
    end
    chk("R6 strobe period", first, 64);

    // R1 R2 R3 R4 R5 R8 vector table
    for (int i = 0; i < NV; i++) begin
      run_pattern(PER_T[i], FWD_T[i], EN_T[i], got);
      if (PER_T[i] == 0)       chk("R8 still inputs", got, EXP_T[i]);
      else if (!EN_T[i])       chk("R5 disabled output", got, EXP_T[i]);
      else if (PER_T[i] < 4)   chk("R3 saturation", got, EXP_T[i]);
      else if (!FWD_T[i])     chk("R4 reverse sign", got, EXP_T[i]);
      else                     chk("R1 R2 duty count", got, EXP_T[i]);
    end

    // R5: enable gates without losing stored value
    run_pattern(8, 1'b1, 1'b1, got);
    chk("R2 before gating", got, 32);
    en_r = 1'b0;
    @(negedge clk);
    chk("R5 gated to zero", int'(vel_o), 0);
    en_r = 1'b1;
    @(negedge clk);
    chk("R5 stored value back", int'(vel_o), 32);

    // R7: reset mid-run clears output
    rst_n = 1'b0;
    @(negedge clk);
    chk("R7 vel_o after mid reset", int'(vel_o), 0);
    chk("R7 valid after mid reset", int'(vel_valid_o), 0);
    rst_n = 1'b1;
    run_pattern(16, 1'b0, 1'b1, got);
    chk("R4 after reset reverse", got, -16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule